// File: doc/BRIEF.md
# Aligned Multi-Domain Test Clock Filter

This block turns a group of free-running, related test clocks into gated capture clocks for at-speed transition testing across clock domains. The clocks in the group are synchronous and their frequencies differ by powers of two. Examples are a fastest clock f and slower clocks at f/2 and f/4. While `scan_en` is high the gated outputs stay quiet. When `scan_en` drops, one shared trigger starts a single capture sequence. During that sequence every domain emits the clock pulses selected by its own pattern word.

All domains start their sequence on the same rising edge of the slowest clock, so the rising edges of all domains line up. Each domain's pattern register is clocked by the fastest clock. A bit of the pattern word therefore stands for one fastest-clock period. Its width is the number of slow pulses multiplied by the fastest-to-slowest ratio. This lets a test program choose any launch/capture pairing between two domains, in either direction, with any multicycle gap.

The shared trigger synchronizes `scan_en` in the slowest domain. It tracks the slow clock's phase by sampling it in the fast domain. It fires on the fast edge just before a common rising edge of all clocks.

Top module: `cfc_group`

## Requirements
- R1: After `scan_en` falls, the capture sequence of every domain starts at the same instant t0. t0 is the third rising edge of `clk_slow` after the fall.
- R2: Bit i of a domain's pattern word stands for fastest-clock period i after t0. For a domain whose clock runs at f/k, a pulse from group g rises exactly at t0 + g·k fastest periods, on an edge of `clk_fast`.
- R3: Group g of a domain at f/k is the bits [g·k+k-1 : g·k]. The domain pulses for group g only when all k bits of the group are 1. A group with any 0 bit produces no pulse.
- R4: One fall of `scan_en` gives exactly one sequence. Holding `scan_en` low longer produces no further pulses. A new sequence needs `scan_en` to go high and then low again.
- R5: The pattern width is N_PULSE × (fastest/slowest ratio), which is 16 by default. An all-ones word gives 16, 8 and 4 pulses on the f, f/2 and f/4 domains.
- R6: A domain's gate enable changes only at boundaries of that domain's clock period. Every gated pulse therefore has the full high time of its domain clock: 10, 20 and 40 ns for f, f/2 and f/4 when f is 50 MHz.
- R7: During reset, and while `scan_en` stays high, all gated outputs stay low.
- R8: Patterns can express both fast-launch/slow-capture and slow-launch/fast-capture pairs, as well as multicycle separations between launch and capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fastest clock of the group; clocks all pattern registers |
| clk_slow | input | 1 | Slowest clock of the group; used for scan-enable sync and phase tracking |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on `clk_fast` |
| clk_dom | input | N_DOM | Free-running clock of each domain, rising on `clk_fast` rising edges |
| scan_en | input | 1 | High in shift mode; a fall starts one capture sequence |
| pat | input | N_DOM×W | One pattern word per domain, bit i = fastest period i after t0 |
| gclk | output | N_DOM | Gated clock of each domain |

## Verification
A fast-domain phase counter that slips shifts the start edge and every gated edge away from the common rising edge. This shows up at the very first pulse of the next sequence as a rise time off t0 by whole fastest periods. If a lane shifts its register by the wrong amount, or tests a single bit instead of a whole group, pulses appear in the wrong domain period or in partial groups, within one domain period of the fault. An enable that changes mid-period shows as a shortened pulse width. A trigger that does not stay disarmed shows as extra pulses while `scan_en` is held low.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  // Largest 4-bit field among the first n fields of a packed vector.
  function automatic int unsigned max_field(input logic [63:0] v, input int unsigned n);
    int unsigned m;
    m = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (int'(v[i*4 +: 4]) > m) m = int'(v[i*4 +: 4]);
    end
    return m;
  endfunction

endpackage

// File: rtl/cfc_trigger.sv
// Shared capture trigger: slow-domain scan-enable sync, fast-domain phase
// tracking of the slowest clock, single-shot start on the fast edge just
// before a common rising edge.
module cfc_trigger #(
  parameter int unsigned PW = 2,
  localparam int unsigned HALF = 1 << (PW - 1)
) (
  input  logic          clk_fast,
  input  logic          clk_slow,
  input  logic          rst_n,
  input  logic          scan_en,
  output logic [PW-1:0] ph_nxt,
  output logic          start
);

  logic          cap_s1, cap_s2;
  logic          lvl, lvl_d;
  logic [PW-1:0] ph;
  logic          locked, locked_nxt;
  logic          done, done_nxt;
  logic          fall, last;

  // scan-enable low is synchronized in the slowest domain
  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      cap_s1 <= 1'b0;
      cap_s2 <= 1'b0;
    end else begin
      cap_s1 <= ~scan_en;
      cap_s2 <= cap_s1;
    end
  end

  // slow clock level sampled mid fast period
  always_ff @(negedge clk_fast or negedge rst_n) begin
    if (!rst_n) lvl <= 1'b0;
    else        lvl <= clk_slow;
  end

  always_comb begin
    fall       = lvl_d & ~lvl;
    ph_nxt     = fall ? PW'(HALF + 1) : ph + 1'b1;
    locked_nxt = locked | fall;
    last       = (ph_nxt == '1);
    start      = locked & last & cap_s2 & ~done;
    done_nxt   = done;
    if (last) done_nxt = cap_s2 & (done | start);
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d  <= 1'b0;
      ph     <= '0;
      locked <= 1'b0;
      done   <= 1'b0;
    end else begin
      lvl_d  <= lvl;
      ph     <= ph_nxt;
      locked <= locked_nxt;
      done   <= done_nxt;
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk_fast) disable iff (!rst_n)
    locked |=> (ph == PW'($past(ph) + 1'b1))); // R2

  AST_START_COMMON: assert property (@(posedge clk_fast) disable iff (!rst_n)
    start |=> (ph == '1)); // R1

  AST_ONE_SHOT: assert property (@(posedge clk_fast) disable iff (!rst_n)
    start |=> !start); // R4

endmodule

// File: rtl/cfc_lane.sv
// One domain: pattern register on the fastest clock, enable updated on the
// fast edge just before each rising edge of the domain clock, gate cell.
module cfc_lane #(
  parameter int unsigned K_L2 = 0,
  parameter int unsigned W    = 16,
  parameter int unsigned PW   = 2,
  localparam int unsigned K   = 1 << K_L2,
  localparam logic [PW-1:0] KM = PW'(K - 1)
) (
  input  logic          clk_fast,
  input  logic          rst_n,
  input  logic          clk_dom,
  input  logic [PW-1:0] ph_nxt,
  input  logic          start,
  input  logic [W-1:0]  pat,
  output logic          gclk
);

  logic [W-1:0] sr, sr_nxt;
  logic         en_q, en_nxt, en_l;
  logic         upd;

  always_comb begin
    upd    = ((ph_nxt & KM) == KM);
    sr_nxt = sr;
    en_nxt = en_q;
    if (upd) begin
      if (start) begin
        en_nxt = &pat[K-1:0];
        sr_nxt = pat >> K;
      end else begin
        en_nxt = &sr[K-1:0];
        sr_nxt = sr >> K;
      end
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      en_q <= 1'b0;
    end else begin
      sr   <= sr_nxt;
      en_q <= en_nxt;
    end
  end

  // gate cell: enable latched while the domain clock is low
  always_latch begin
    if (!rst_n)        en_l = 1'b0;
    else if (!clk_dom) en_l = en_q;
  end

  assign gclk = clk_dom & en_l;

  AST_EN_ON_BOUNDARY: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !upd |=> $stable(en_q)); // R6

endmodule

// File: rtl/cfc_group.sv
module cfc_group
  import cfc_pkg::*;
#(
  parameter int unsigned N_DOM   = 3,
  parameter logic [N_DOM*4-1:0] DIV_LOG2 = 12'h210,
  parameter int unsigned N_PULSE = 4,
  localparam int unsigned MAX_L2 = max_field(64'(DIV_LOG2), N_DOM),
  localparam int unsigned W      = N_PULSE << MAX_L2,
  localparam int unsigned PW     = MAX_L2
) (
  input  logic                      clk_fast,
  input  logic                      clk_slow,
  input  logic                      rst_n,
  input  logic [N_DOM-1:0]          clk_dom,
  input  logic                      scan_en,
  input  logic [N_DOM-1:0][W-1:0]   pat,
  output logic [N_DOM-1:0]          gclk
);

  logic          rst_q1, rst_q2;
  logic [PW-1:0] ph_nxt;
  logic          start;

  // asynchronous assert, release on clk_fast
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  cfc_trigger #(.PW(PW)) u_trig (
    .clk_fast (clk_fast),
    .clk_slow (clk_slow),
    .rst_n    (rst_q2),
    .scan_en  (scan_en),
    .ph_nxt   (ph_nxt),
    .start    (start)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_lane
    cfc_lane #(
      .K_L2 (int'(DIV_LOG2[d*4 +: 4])),
      .W    (W),
      .PW   (PW)
    ) u_lane (
      .clk_fast (clk_fast),
      .rst_n    (rst_q2),
      .clk_dom  (clk_dom[d]),
      .ph_nxt   (ph_nxt),
      .start    (start),
      .pat      (pat[d]),
      .gclk     (gclk[d])
    );
  end

endmodule

// File: tb/cfc_group_bench.sv
`timescale 1ns/100ps
module cfc_group_bench;

  logic              clk_fast, clk_div2, clk_div4, rst_n, scan_en;
  logic [2:0][15:0]  pat;
  logic [2:0]        gclk;
  int                n_tests, n_fail;
  bit                finished;

  logic [2:0] prev;
  time        rise_t [3][64];
  time        wid_t  [3][64];
  time        last_rise [3];
  int         nr [3];

  cfc_group u_cfc_group (
    .clk_fast (clk_fast),
    .clk_slow (clk_div4),
    .rst_n    (rst_n),
    .clk_dom  ({clk_div4, clk_div2, clk_fast}),
    .scan_en  (scan_en),
    .pat      (pat),
    .gclk     (gclk)
  );

  // 50 MHz fastest clock; f/2 and f/4 rise on its rising edges
  initial begin
    clk_fast = 0; clk_div2 = 0; clk_div4 = 0;
    #10;
    forever begin
      for (int p = 0; p < 4; p++) begin
        clk_fast = 1; clk_div2 = (p % 2 == 0); clk_div4 = (p < 2);
        #10;
        clk_fast = 0;
        #10;
      end
    end
  end

  // edge logger: samples mid half-period, edges fall on 10 ns marks
  initial begin
    prev = '0;
    for (int d = 0; d < 3; d++) nr[d] = 0;
    #5;
    forever begin
      for (int d = 0; d < 3; d++) begin
        if (gclk[d] && !prev[d]) begin
          rise_t[d][nr[d] % 64] = $time - 5;
          last_rise[d] = $time - 5;
        end
        if (!gclk[d] && prev[d]) begin
          wid_t[d][nr[d] % 64] = $time - 5 - last_rise[d];
          nr[d]++;
        end
      end
      prev = gclk;
      #10;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one capture sequence with patterns p0 (f), p1 (f/2), p2 (f/4)
  task automatic run_case(input string nm, input logic [15:0] p0, p1, p2,
                          input int hold_slow, input string req);
    int  base [3];
    time t0;
    logic [15:0] pw;
    for (int d = 0; d < 3; d++) base[d] = nr[d];
    pat[0] = p0; pat[1] = p1; pat[2] = p2;
    @(negedge clk_fast) scan_en = 0;
    repeat (3) @(posedge clk_div4);
    t0 = $time;
    repeat (hold_slow) @(posedge clk_div4);
    @(negedge clk_fast) scan_en = 1;
    repeat (8) @(posedge clk_div4);
    for (int d = 0; d < 3; d++) begin
      int  k, cnt, idx;
      bit  tok, wok;
      longint bad_t, bad_e;
      k = 1 << d;
      pw = (d == 0) ? p0 : (d == 1) ? p1 : p2;
      cnt = 0; tok = 1; wok = 1; bad_t = 0; bad_e = 0;
      for (int g = 0; g < 16 / k; g++) begin
        if (((pw >> (g * k)) & ((16'd1 << k) - 1)) == ((16'd1 << k) - 1)) begin
          idx = base[d] + cnt;
          if (idx < nr[d]) begin
            if (rise_t[d][idx % 64] != t0 + g * k * 20) begin
              tok = 0; bad_t = longint'(rise_t[d][idx % 64]); bad_e = longint'(t0 + g * k * 20);
            end
            if (wid_t[d][idx % 64] != k * 10) wok = 0;
          end
          cnt++;
        end
      end
      check(nr[d] - base[d] == cnt, "R3", $sformatf("%s d%0d pulse count", nm, d),
            nr[d] - base[d], cnt);
      check(tok, req, $sformatf("%s d%0d rise time (R2)", nm, d), bad_t, bad_e);
      check(wok, "R6", $sformatf("%s d%0d pulse width", nm, d), wok, 1);
    end
  endtask

  task automatic t_reset_idle();
    check(gclk == 3'b000, "R7", "outputs during reset", gclk, 0);
    @(negedge clk_fast) rst_n = 1;
    repeat (10) @(posedge clk_div4);
    check(nr[0] + nr[1] + nr[2] == 0, "R7", "pulses while scan_en high",
          nr[0] + nr[1] + nr[2], 0);
  endtask

  task automatic t_intra();
    run_case("intra fast", 16'h0003, 16'h0000, 16'h0000, 5, "R2");
  endtask

  task automatic t_fast_launch_slow_capture();
    run_case("R8 fast launch slow capture", 16'h0001, 16'h0000, 16'h00F0, 5, "R8");
  endtask

  task automatic t_slow_launch_fast_capture();
    run_case("R8 slow launch fast capture multicycle", 16'h0100, 16'h0003, 16'h0000, 5, "R8");
  endtask

  task automatic t_partial_groups();
    run_case("R3 partial groups", 16'h0000, 16'h000E, 16'h0F70, 5, "R3");
  endtask

  task automatic t_hold_long();
    run_case("R4 long hold", 16'h8001, 16'hC000, 16'hF000, 14, "R4");
  endtask

  task automatic t_full();
    int  b [3];
    time t0;
    for (int d = 0; d < 3; d++) b[d] = nr[d];
    run_case("R5 all ones", 16'hFFFF, 16'hFFFF, 16'hFFFF, 5, "R5");
    check(nr[0] - b[0] == 16 && nr[1] - b[1] == 8 && nr[2] - b[2] == 4, "R5",
          "pulse totals f f/2 f/4", nr[0] - b[0] + nr[1] - b[1] + nr[2] - b[2], 28);
    t0 = rise_t[0][b[0] % 64];
    check(rise_t[1][b[1] % 64] == t0 && rise_t[2][b[2] % 64] == t0, "R1",
          "first edge common to all domains", longint'(rise_t[2][b[2] % 64]), longint'(t0));
  endtask

  initial begin
    n_tests = 0; n_fail = 0; finished = 0;
    rst_n = 0; scan_en = 1; pat = '0;
    repeat (6) @(posedge clk_fast);
    #1;
    t_reset_idle();
    t_intra();
    t_fast_launch_slow_capture();
    t_slow_launch_fast_capture();
    t_partial_groups();
    t_hold_long();
    t_full();
    t_intra();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule